// File: doc/BRIEF.md
# Block-Matching SAD Search Engine

This block looks for the best match of an 8x8 block of 16-bit pixels inside a reference search area. For every candidate offset in a window of configurable width and height, it computes the sum of absolute differences (SAD) between the current block and the reference pixels under that candidate. It then reports the lowest SAD and the offset where it was found.

The current block is written one pixel at a time through a small load port. The reference area is streamed one full row per beat over a valid/ready handshake. The block keeps an 8-row window of reference rows in local registers. Moving one candidate down takes in one new row and reuses the seven already held. Moving one candidate to the right only advances a column offset into the held rows, so no reference pixel is fetched twice. All 64 absolute differences of a candidate are formed in one cycle, so one candidate is scored per clock while a band is scanned.

A search begins with a start pulse. The window size is sampled at that pulse. The search ends with a one-cycle done pulse. The result then stays put until the next search begins.

Top module: `sad_search`

## Requirements
- R1: For a candidate at offset (x, y), the cost is the sum over r, c in 0..7 of |cur[r][c] - ref[y+r][x+c]|, with unsigned 16-bit pixels. `best_sad` reports the lowest such cost.
- R2: Every offset with x in 0..win_w-1 and y in 0..win_h-1 is scored. `best_x` is the column offset and `best_y` is the row offset of the reported minimum.
- R3: The cost is held in 22 bits and never wraps. The largest possible value, 64 x 65535 = 4194240, is reported exactly.
- R4: When several candidates share the lowest cost, the one met first in raster order is kept. Raster order means y ascending, and x ascending within each y.
- R5: A reference beat carries one row of 8+MAX_W-1 pixels, with pixel column i in bits [16*i+15:16*i]. Columns at or beyond 8+win_w-1 are ignored. A search accepts exactly 8+win_h-1 beats, in top-to-bottom row order.
- R6: After the 8th row is accepted, and after each further row, `ref_ready` stays low for exactly win_w cycles while that band of candidates is scored. `ref_ready` is low whenever no search is running.
- R7: `done` is high for exactly one cycle after the last candidate is scored. From then until the next start, `best_sad`, `best_x` and `best_y` do not change, whatever arrives on the other inputs.
- R8: After reset, `done` is 0, `ref_ready` is 0 and `best_sad`, `best_x` and `best_y` are 0.
- R9: A current-block write with `cur_we` high stores `cur_data` at row `cur_addr[5:3]`, column `cur_addr[2:0]`.
- R10: `win_w` and `win_h` take any value from 1 up to MAX_W and MAX_H respectively, and are sampled on the start pulse. A 1x1 window scores a single candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a search when the block is idle |
| win_w | input | $clog2(MAX_W+1) | Number of horizontal candidate offsets |
| win_h | input | $clog2(MAX_H+1) | Number of vertical candidate offsets |
| cur_we | input | 1 | Current-block pixel write enable |
| cur_addr | input | 6 | Current-block pixel address, row*8+col |
| cur_data | input | 16 | Current-block pixel value |
| ref_valid | input | 1 | Reference row beat valid |
| ref_ready | output | 1 | Reference row beat accepted when high with valid |
| ref_row | input | 16*(8+MAX_W-1) | One reference row, column i in bits 16*i upward |
| best_sad | output | 22 | Lowest SAD found |
| best_x | output | $clog2(MAX_W+1) | Column offset of the lowest SAD |
| best_y | output | $clog2(MAX_H+1) | Row offset of the lowest SAD |
| done | output | 1 | One-cycle pulse at the end of a search |

## Verification
The bench uses the default MAX_W = MAX_H = 8. This gives 15-pixel reference rows and allows searches from a single candidate up to the full 8x8 window of 64 candidates. Within that range the vectors cover:
- degenerate one-row and one-column windows;
- uneven sizes such as 3x5 and 6x7, where the unused right-hand columns of each beat must be ignored;
- a planted exact match;
- constant and saturated reference areas, where every candidate ties, including at the 22-bit maximum cost.

Gaps on the valid line show that the row count and the ready-low spacing of win_w cycles do not depend on how fast rows arrive.

// File: rtl/sad_search.sv
module sad_search #(
  parameter int PIX_W = 16,
  parameter int BLK   = 8,
  parameter int MAX_W = 8,
  parameter int MAX_H = 8,
  localparam int XW      = $clog2(MAX_W + 1),
  localparam int YW      = $clog2(MAX_H + 1),
  localparam int LW      = $clog2(BLK),
  localparam int ROW_PIX = BLK + MAX_W - 1,
  localparam int SAD_W   = PIX_W + $clog2(BLK * BLK)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [XW-1:0]            win_w,
  input  logic [YW-1:0]            win_h,
  input  logic                     cur_we,
  input  logic [2*LW-1:0]          cur_addr,
  input  logic [PIX_W-1:0]         cur_data,
  input  logic                     ref_valid,
  output logic                     ref_ready,
  input  logic [ROW_PIX*PIX_W-1:0] ref_row,
  output logic [SAD_W-1:0]         best_sad,
  output logic [XW-1:0]            best_x,
  output logic [YW-1:0]            best_y,
  output logic                     done
);
  localparam int CI_W = $clog2(ROW_PIX);
  localparam int RW   = $clog2(BLK + 1);

  typedef enum logic [1:0] {IDLE, FILL, SCAN, STEP} state_t;
  state_t st;

  logic [PIX_W-1:0] cur [BLK][BLK];
  logic [PIX_W-1:0] win [BLK][ROW_PIX];

  logic [XW-1:0] w_q, x;
  logic [YW-1:0] h_q, y;
  logic [RW-1:0] rows;

  logic             p_vld, p_last, best_vld;
  logic [SAD_W-1:0] p_sad, sad_c;
  logic [XW-1:0]    p_x;
  logic [YW-1:0]    p_y;

  wire go       = start && (st == IDLE) && !p_vld;
  assign ref_ready = (st == FILL) || (st == STEP);
  wire acc      = ref_valid && ref_ready;
  wire x_end    = (x == w_q - XW'(1));
  wire y_end    = (y == h_q - YW'(1));

  always_ff @(posedge clk) begin
    if (cur_we) cur[cur_addr[2*LW-1:LW]][cur_addr[LW-1:0]] <= cur_data;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      for (int r = 0; r < BLK - 1; r++) win[r] <= win[r+1];
      for (int i = 0; i < ROW_PIX; i++) win[BLK-1][i] <= ref_row[i*PIX_W +: PIX_W];
    end
  end

  always_comb begin
    logic [PIX_W-1:0] a, b;
    logic [CI_W-1:0]  ci;
    sad_c = '0;
    for (int r = 0; r < BLK; r++) begin
      for (int c = 0; c < BLK; c++) begin
        ci = CI_W'(x) + CI_W'(c);
        a  = cur[r][c];
        b  = win[r][ci];
        sad_c = sad_c + SAD_W'((a > b) ? a - b : b - a);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      w_q  <= '0;
      h_q  <= '0;
      x    <= '0;
      y    <= '0;
      rows <= '0;
    end else begin
      case (st)
        IDLE: if (go) begin
          w_q  <= win_w;
          h_q  <= win_h;
          x    <= '0;
          y    <= '0;
          rows <= '0;
          st   <= FILL;
        end
        FILL: if (acc) begin
          rows <= rows + RW'(1);
          if (rows == RW'(BLK - 1)) st <= SCAN;
        end
        SCAN: begin
          if (x_end) begin
            x  <= '0;
            st <= y_end ? IDLE : STEP;
          end else begin
            x <= x + XW'(1);
          end
        end
        STEP: if (acc) begin
          y  <= y + YW'(1);
          st <= SCAN;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_last <= 1'b0;
      p_sad  <= '0;
      p_x    <= '0;
      p_y    <= '0;
    end else begin
      p_vld  <= (st == SCAN);
      p_last <= (st == SCAN) && x_end && y_end;
      p_sad  <= sad_c;
      p_x    <= x;
      p_y    <= y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_vld <= 1'b0;
      best_sad <= '0;
      best_x   <= '0;
      best_y   <= '0;
      done     <= 1'b0;
    end else begin
      done <= p_vld && p_last;
      if (go) begin
        best_vld <= 1'b0;
      end else if (p_vld && (!best_vld || p_sad < best_sad)) begin
        best_vld <= 1'b1;
        best_sad <= p_sad;
        best_x   <= p_x;
        best_y   <= p_y;
      end
    end
  end
endmodule

// File: rtl/sad_search_chk.sv
module sad_search_chk #(
  parameter int PIX_W = 16,
  parameter int BLK   = 8,
  parameter int XW    = 4,
  parameter int YW    = 4,
  parameter int SAD_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             done,
  input logic             ref_ready,
  input logic             best_vld,
  input logic [SAD_W-1:0] best_sad,
  input logic [XW-1:0]    best_x,
  input logic [YW-1:0]    best_y,
  input logic [XW-1:0]    w_q,
  input logic [YW-1:0]    h_q
);
  localparam longint unsigned MAXSAD = longint'(BLK) * BLK * ((longint'(1) << PIX_W) - 1);

  logic fin;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fin <= 1'b0;
    else if (go)   fin <= 1'b0;
    else if (done) fin <= 1'b1;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    64'(best_sad) <= MAXSAD);

  assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_x < w_q) && (best_y < h_q));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !go) |=> $stable(best_sad) && $stable(best_x) && $stable(best_y));

  assert_ready_low_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ref_ready);

  assert_best_never_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (best_vld && !go) |=> best_sad <= $past(best_sad));
endmodule

bind sad_search sad_search_chk #(
  .PIX_W(PIX_W), .BLK(BLK), .XW(XW), .YW(YW), .SAD_W(SAD_W)
) u_sad_search_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .done(done), .ref_ready(ref_ready),
  .best_vld(best_vld), .best_sad(best_sad), .best_x(best_x), .best_y(best_y),
  .w_q(w_q), .h_q(h_q)
);

// File: tb/test_sad_search.sv
module test_sad_search;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 16;
  localparam int BLK = 8;
  localparam int MAX_W = 8;
  localparam int MAX_H = 8;
  localparam int XW = $clog2(MAX_W + 1);
  localparam int YW = $clog2(MAX_H + 1);
  localparam int ROW_PIX = BLK + MAX_W - 1;
  localparam int REF_ROWS = BLK + MAX_H - 1;
  localparam int NVEC = 10;

  // fields: w[31:24] h[23:16] mode[15:12] gap[11:8] seed[7:0]
  // mode 0 random, 1 planted match, 2 constant ref, 3 saturated, 4 small values
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd8, 8'd8, 4'd0, 4'd0, 8'd1},
    {8'd8, 8'd8, 4'd1, 4'd1, 8'd21},
    {8'd3, 8'd5, 4'd0, 4'd1, 8'd3},
    {8'd1, 8'd1, 4'd0, 4'd0, 8'd4},
    {8'd8, 8'd1, 4'd4, 4'd0, 8'd5},
    {8'd1, 8'd8, 4'd1, 4'd0, 8'd6},
    {8'd5, 8'd3, 4'd2, 4'd0, 8'd7},
    {8'd8, 8'd8, 4'd3, 4'd0, 8'd8},
    {8'd4, 8'd4, 4'd4, 4'd1, 8'd9},
    {8'd6, 8'd7, 4'd1, 4'd1, 8'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [XW-1:0] win_w = '0;
  logic [YW-1:0] win_h = '0;
  logic cur_we = 1'b0;
  logic [5:0] cur_addr = '0;
  logic [PIX_W-1:0] cur_data = '0;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic [ROW_PIX*PIX_W-1:0] ref_row = '0;
  logic [21:0] best_sad;
  logic [XW-1:0] best_x;
  logic [YW-1:0] best_y;
  logic done;

  int checks = 0;
  int errors = 0;
  int unsigned lcg = 32'h1234;
  int cur_m [BLK][BLK];
  int ref_m [REF_ROWS][ROW_PIX];

  always #(CLK_PERIOD/2) clk = ~clk;

  sad_search #(.PIX_W(PIX_W), .BLK(BLK), .MAX_W(MAX_W), .MAX_H(MAX_H)) i_sad_search (
    .clk(clk), .rst_n(rst_n), .start(start), .win_w(win_w), .win_h(win_h),
    .cur_we(cur_we), .cur_addr(cur_addr), .cur_data(cur_data),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row),
    .best_sad(best_sad), .best_x(best_x), .best_y(best_y), .done(done)
  );

  function automatic int rnd16();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[23:8]);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_model(input int w, input int h, input int mode, input int seed);
    lcg = 32'(seed) * 32'd7919 + 32'd17;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        case (mode)
          3: cur_m[r][c] = 0;
          4: cur_m[r][c] = rnd16() & 3;
          default: cur_m[r][c] = rnd16();
        endcase
    for (int r = 0; r < REF_ROWS; r++)
      for (int c = 0; c < ROW_PIX; c++)
        case (mode)
          2: ref_m[r][c] = 1000;
          3: ref_m[r][c] = 65535;
          4: ref_m[r][c] = rnd16() & 3;
          default: ref_m[r][c] = rnd16();
        endcase
    if (mode == 1) begin
      for (int r = 0; r < BLK; r++)
        for (int c = 0; c < BLK; c++)
          ref_m[(seed % h) + r][(seed % w) + c] = cur_m[r][c];
    end
  endtask

  task automatic model(input int w, input int h, output longint bs, output int bx, output int by);
    bs = -1; bx = 0; by = 0;
    for (int yy = 0; yy < h; yy++)
      for (int xx = 0; xx < w; xx++) begin
        longint s = 0;
        for (int r = 0; r < BLK; r++)
          for (int c = 0; c < BLK; c++) begin
            int d = cur_m[r][c] - ref_m[yy + r][xx + c];
            s += (d < 0) ? -d : d;
          end
        if (bs < 0 || s < bs) begin bs = s; bx = xx; by = yy; end
      end
  endtask

  task automatic run_vec(input int w, input int h, input int mode, input int gap, input int seed);
    longint ebs; int ebx, eby;
    int idx, cyc, low, done_cnt, tot;
    bit fin;
    logic [21:0] hs; logic [XW-1:0] hx; logic [YW-1:0] hy;
    string tag;
    fill_model(w, h, mode, seed);
    model(w, h, ebs, ebx, eby);
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) begin
        @(negedge clk);
        cur_we = 1'b1; cur_addr = 6'(r * 8 + c); cur_data = PIX_W'(cur_m[r][c]);
      end
    @(negedge clk);
    cur_we = 1'b0; start = 1'b1; win_w = XW'(w); win_h = YW'(h);
    @(negedge clk);
    start = 1'b0;
    tot = BLK + h - 1; idx = 0; cyc = 0; low = 0; done_cnt = 0; fin = 0;
    while (!fin && cyc < 3000) begin
      if (idx < tot) begin
        ref_valid = (gap != 0) ? (cyc % 3 != 2) : 1'b1;
        for (int i = 0; i < ROW_PIX; i++) ref_row[i*PIX_W +: PIX_W] = PIX_W'(ref_m[idx][i]);
      end else begin
        ref_valid = 1'b0;
      end
      if (ref_valid && ref_ready) begin
        if (idx >= BLK) chk(low == w, "R6 ready-low cycles per band", low, w);
        idx++; low = 0;
      end else if (idx >= BLK && idx < tot && !ref_ready) begin
        low++;
      end
      if (done) done_cnt++;
      else if (done_cnt > 0) fin = 1;
      @(negedge clk);
      cyc++;
    end
    ref_valid = 1'b0;
    chk(fin, "watchdog search did not end", cyc, 0);
    chk(done_cnt == 1, "R7 done pulse length", done_cnt, 1);
    chk(idx == tot, "R5 rows accepted", idx, tot);
    case (mode)
      3: tag = "R3 saturated sad";
      2: tag = "R4 tie sad";
      1: tag = "R9 planted match sad";
      default: tag = (w == 1 && h == 1) ? "R10 single candidate sad" : "R1 sad value";
    endcase
    chk(best_sad == 22'(ebs), tag, best_sad, ebs);
    tag = (mode == 2 || mode == 3) ? "R4 tie keeps first x" : "R2 best_x";
    chk(best_x == XW'(ebx), tag, best_x, ebx);
    tag = (mode == 2 || mode == 3) ? "R4 tie keeps first y" : "R2 best_y";
    chk(best_y == YW'(eby), tag, best_y, eby);
    hs = best_sad; hx = best_x; hy = best_y;
    for (int k = 0; k < 6; k++) begin
      ref_valid = 1'b1;
      ref_row = {ROW_PIX{16'h5A5A}};
      cur_we = 1'b1; cur_addr = 6'(k); cur_data = 16'hFFFF;
      @(negedge clk);
      chk(!ref_ready, "R6 ready low while idle", ref_ready, 0);
    end
    ref_valid = 1'b0; cur_we = 1'b0;
    chk(best_sad == hs && best_x == hx && best_y == hy && !done,
        "R7 result held after done", best_sad, hs);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 reset done", done, 0);
    chk(ref_ready == 1'b0, "R8 reset ready", ref_ready, 0);
    chk(best_sad == '0 && best_x == '0 && best_y == '0, "R8 reset result", best_sad, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NVEC; v++)
      run_vec(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:12]),
              int'(VEC[v][11:8]), int'(VEC[v][7:0]));
    // R4 directed: small-value window where ties among many candidates are likely
    run_vec(8, 8, 4, 0, 77);
    // R10 directed: back-to-back searches with the largest and smallest window
    run_vec(MAX_W, MAX_H, 0, 1, 91);
    run_vec(1, 1, 1, 0, 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog global timeout actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule